// File: doc/BRIEF.md
# Configurable 32/64-bit Funnel Shifter

This unit joins two source words, a low word and a high word, into a funnel and returns one word-wide slice of it. The slice can be taken to the left or to the right. The shift amount comes either from a signed register operand or from an unsigned immediate field. Before use, the amount is reduced to a legal range: it is either wrapped (masked) or clamped, depending on a select input.

A two-bit type code sets the size of the funnel. In the narrow type the funnel is one word wide. In the two wide types it is two words wide, and a wide right shift can be logical or arithmetic.

Fixed results apply at an amount of zero and at an amount of exactly one word width. The datapath itself is combinational. It feeds one output register, and a valid flag travels alongside the data. The block suits an integer pipeline in which a shift issues every cycle.

Top module: `funnel_shift_unit`

## Requirements
- R1: The type code `shf_type` selects the funnel size. 2'b00 is the narrow type, with size W (W = `WORD_W`, default 32). 2'b01 is unsigned wide, with size 2W. 2'b10 is signed wide, with size 2W. Code 2'b11 behaves exactly like 2'b01.
- R2: When `use_imm` is 1, the amount is `amt_imm`, zero-extended, and `amt_reg` has no effect on the result. When `use_imm` is 0, the amount is `amt_reg`, read as a two's-complement signed value.
- R3: When `wrap_en` is 1, the effective amount is the raw amount ANDed with (size-1).
- R4: When `wrap_en` is 0, the effective amount is the raw amount clamped to the range 0 to size inclusive. Negative amounts become 0.
- R5: A sub-shift whose distance is W or more contributes zero. In the narrow type at amount 0, a right shift therefore yields `lo_word` and a left shift yields `hi_word`.
- R6: For a right shift with effective amount s < W (and s > 0 in the wide types), the result is (lo >> s) | (hi << (W-s)).
- R7: For a left shift with effective amount s < W (and s > 0 in the wide types), the result is (lo >> (W-s)) | (hi << s).
- R8: In the narrow type, at s == W a right shift yields `hi_word` and a left shift yields `lo_word`.
- R9: In the wide types, for W <= s < 2W a right shift yields hi >> (s-W), and a left shift yields lo << (s-W). The right shift is arithmetic for code 2'b10 and logical otherwise. At s == 2W the result is 0 in every direction and in both wide types.
- R10: In the wide types, at s == 0 the result is `hi_word` for either direction.
- R11: `out_valid` equals `in_valid` delayed by one clock. `out_word` takes the new result only in a cycle with `in_valid` = 1, and otherwise holds its value.
- R12: While reset is active, and after its release until the first valid input, `out_valid` is 0 and `out_word` is 0. Reset asserts asynchronously and is released through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid; loads the output register |
| dir_left | input | 1 | 1 = left funnel shift, 0 = right |
| wrap_en | input | 1 | 1 = wrap the amount, 0 = clamp it |
| use_imm | input | 1 | 1 = take the amount from `amt_imm` |
| shf_type | input | 2 | 00 narrow, 01 unsigned wide, 10 signed wide, 11 as 01 |
| lo_word | input | WORD_W | Low source word |
| hi_word | input | WORD_W | High source word |
| amt_reg | input | AMT_W | Signed register amount |
| amt_imm | input | IMM_W | Unsigned immediate amount |
| out_valid | output | 1 | Result valid |
| out_word | output | WORD_W | Registered result |

## Verification
Every combination of type code, direction and wrap/clamp select is swept with register amounts from -70 to 140. The sweep is then repeated with all 64 immediate values while `amt_reg` holds a decoy value.

Three source-word pairs are used:
- one with the high word negative, which exposes any confusion between arithmetic and logical shifting;
- one with distinct nibbles, which exposes wrong crossing-bit positions;
- one with all-ones against a single bit, which exposes an off-by-one in the complementary amount.

The amount range crosses 0, W, 2W and the clamp limits. It separates wrap from clamp behaviour, the zero and full-width special cases, and sub-shifts that wrongly take their distance modulo the word width. Separate cycles with no valid input check that the result register holds its value.

// File: rtl/fsh_pkg.sv
package fsh_pkg;

  typedef enum logic [1:0] {
    FSH_NARROW = 2'b00,
    FSH_WIDE_U = 2'b01,
    FSH_WIDE_S = 2'b10,
    FSH_WIDE_X = 2'b11
  } fsh_type_e;

endpackage

// File: rtl/fsh_rst_sync.sv
module fsh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      assign sync_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[LAST];

endmodule

// File: rtl/fsh_amount_norm.sv
module fsh_amount_norm #(
  parameter int WORD_W = 32,
  parameter int AMT_W  = 32,
  parameter int IMM_W  = 6,
  localparam int SW    = $clog2(2 * WORD_W) + 1
) (
  input  logic             use_imm,
  input  logic             wrap_en,
  input  logic             wide,
  input  logic [AMT_W-1:0] amt_reg,
  input  logic [IMM_W-1:0] amt_imm,
  output logic [SW-1:0]    amt_norm
);

  localparam logic [AMT_W-1:0] LIM_N = AMT_W'(WORD_W);
  localparam logic [AMT_W-1:0] LIM_W = AMT_W'(2 * WORD_W);
  localparam logic [SW-1:0]    SZ_N  = SW'(WORD_W);
  localparam logic [SW-1:0]    SZ_W  = SW'(2 * WORD_W);

  logic [AMT_W-1:0] imm_ext;
  logic [AMT_W-1:0] raw;
  logic [AMT_W-1:0] lim;
  logic [SW-1:0]    size;
  logic [SW-1:0]    wrap_val;
  logic [SW-1:0]    clamp_val;

  generate
    if (IMM_W < AMT_W) begin : g_pad
      assign imm_ext = {{(AMT_W - IMM_W){1'b0}}, amt_imm};
    end else begin : g_trim
      assign imm_ext = amt_imm[AMT_W-1:0];
    end
  endgenerate

  always_comb begin
    raw  = use_imm ? imm_ext : amt_reg;
    lim  = wide ? LIM_W : LIM_N;
    size = wide ? SZ_W : SZ_N;

    // masking with size-1: both sizes are powers of two
    if (wide) begin
      wrap_val = {1'b0, raw[SW-2:0]};
    end else begin
      wrap_val = {2'b00, raw[SW-3:0]};
    end

    if (raw[AMT_W-1]) begin
      clamp_val = '0;
    end else if (raw > lim) begin
      clamp_val = size;
    end else begin
      clamp_val = raw[SW-1:0];
    end

    amt_norm = wrap_en ? wrap_val : clamp_val;
  end

endmodule

// File: rtl/fsh_funnel_core.sv
module fsh_funnel_core
  import fsh_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SW    = $clog2(2 * WORD_W) + 1
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [SW-1:0]     amt,
  input  logic              dir_left,
  input  fsh_type_e         typ,
  output logic [WORD_W-1:0] result
);

  localparam logic [SW-1:0] WV = SW'(WORD_W);

  // Bounded shifters: any distance of a full word or more gives zero.
  function automatic logic [WORD_W-1:0] sub_right(input logic [WORD_W-1:0] x,
                                                  input logic [SW-1:0] n,
                                                  input logic arith);
    if (n >= WV) begin
      return '0;
    end else if (arith) begin
      return WORD_W'($signed(x) >>> n);
    end else begin
      return x >> n;
    end
  endfunction

  function automatic logic [WORD_W-1:0] sub_left(input logic [WORD_W-1:0] x,
                                                 input logic [SW-1:0] n);
    if (n >= WV) begin
      return '0;
    end else begin
      return x << n;
    end
  endfunction

  logic              wide;
  logic              arith;
  logic [SW-1:0]     comp;
  logic [SW-1:0]     reduced;
  logic [WORD_W-1:0] part_r;
  logic [WORD_W-1:0] part_l;
  logic [WORD_W-1:0] part_sel;
  logic [WORD_W-1:0] upper_sel;

  always_comb begin
    wide    = (typ != FSH_NARROW);
    arith   = (typ == FSH_WIDE_S);
    comp    = WV - amt;
    reduced = amt - WV;

    part_r   = sub_right(lo_word, amt, 1'b0) | sub_left(hi_word, comp);
    part_l   = sub_right(lo_word, comp, 1'b0) | sub_left(hi_word, amt);
    part_sel = dir_left ? part_l : part_r;

    upper_sel = dir_left ? sub_left(lo_word, reduced)
                         : sub_right(hi_word, reduced, arith);

    if (!wide) begin
      if (amt == WV) begin
        result = dir_left ? lo_word : hi_word;
      end else begin
        result = part_sel;
      end
    end else if (amt == '0) begin
      result = hi_word;
    end else if (amt < WV) begin
      result = part_sel;
    end else begin
      result = upper_sel;
    end
  end

endmodule

// File: rtl/funnel_shift_unit.sv
module funnel_shift_unit
  import fsh_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int AMT_W  = 32,
  parameter int IMM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              dir_left,
  input  logic              wrap_en,
  input  logic              use_imm,
  input  logic [1:0]        shf_type,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [AMT_W-1:0]  amt_reg,
  input  logic [IMM_W-1:0]  amt_imm,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);

  localparam int SW = $clog2(2 * WORD_W) + 1;

  logic              rst_sync_n;
  fsh_type_e         typ;
  logic              wide;
  logic [SW-1:0]     amt_norm;
  logic [WORD_W-1:0] core_res;
  logic              valid_d;
  logic              valid_q;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;

  assign typ  = fsh_type_e'(shf_type);
  assign wide = (typ != FSH_NARROW);

  fsh_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsh_amount_norm #(
    .WORD_W (WORD_W),
    .AMT_W  (AMT_W),
    .IMM_W  (IMM_W)
  ) u_norm (
    .use_imm  (use_imm),
    .wrap_en  (wrap_en),
    .wide     (wide),
    .amt_reg  (amt_reg),
    .amt_imm  (amt_imm),
    .amt_norm (amt_norm)
  );

  fsh_funnel_core #(.WORD_W(WORD_W)) u_core (
    .lo_word  (lo_word),
    .hi_word  (hi_word),
    .amt      (amt_norm),
    .dir_left (dir_left),
    .typ      (typ),
    .result   (core_res)
  );

  always_comb begin
    valid_d = in_valid;
    word_en = in_valid;
    word_d  = core_res;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign out_valid = valid_q;
  assign out_word  = word_q;

endmodule

// File: rtl/fsh_checker.sv
module fsh_checker #(
  parameter int WORD_W = 32,
  parameter int AMT_W  = 32,
  parameter int IMM_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              dir_left,
  input logic              wrap_en,
  input logic              use_imm,
  input logic [1:0]        shf_type,
  input logic [WORD_W-1:0] lo_word,
  input logic [WORD_W-1:0] hi_word,
  input logic [AMT_W-1:0]  amt_reg,
  input logic [IMM_W-1:0]  amt_imm,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word
);

  localparam logic [IMM_W-1:0] IMM_FULL = IMM_W'(WORD_W);
  localparam logic [AMT_W-1:0] BIG_LIM  = AMT_W'(2 * WORD_W);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word))); // R11

  AST_WIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shf_type != 2'b00 && use_imm && amt_imm == '0)
    |=> out_word == $past(hi_word)); // R10

  AST_NARROW_FULL_R: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shf_type == 2'b00 && use_imm && !wrap_en && !dir_left && amt_imm == IMM_FULL)
    |=> out_word == $past(hi_word)); // R8

  AST_NARROW_FULL_L: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shf_type == 2'b00 && use_imm && !wrap_en && dir_left && amt_imm == IMM_FULL)
    |=> out_word == $past(lo_word)); // R8

  AST_CLAMP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shf_type != 2'b00 && !use_imm && !wrap_en && amt_reg[AMT_W-1])
    |=> out_word == $past(hi_word)); // R4

  AST_CLAMP_BIG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shf_type != 2'b00 && !use_imm && !wrap_en && !amt_reg[AMT_W-1] && amt_reg >= BIG_LIM)
    |=> out_word == '0); // R9

endmodule

bind funnel_shift_unit fsh_checker #(
  .WORD_W (WORD_W),
  .AMT_W  (AMT_W),
  .IMM_W  (IMM_W)
) u_fsh_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .dir_left  (dir_left),
  .wrap_en   (wrap_en),
  .use_imm   (use_imm),
  .shf_type  (shf_type),
  .lo_word   (lo_word),
  .hi_word   (hi_word),
  .amt_reg   (amt_reg),
  .amt_imm   (amt_imm),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/funnel_shift_unit_bench.sv
module funnel_shift_unit_bench;

  localparam int W  = 32;
  localparam int AW = 32;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          dir_left;
  logic          wrap_en;
  logic          use_imm;
  logic [1:0]    shf_type;
  logic [W-1:0]  lo_word;
  logic [W-1:0]  hi_word;
  logic [AW-1:0] amt_reg;
  logic [IW-1:0] amt_imm;
  logic          out_valid;
  logic [W-1:0]  out_word;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  funnel_shift_unit #(.WORD_W(W), .AMT_W(AW), .IMM_W(IW)) u_funnel_shift_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .dir_left (dir_left),
    .wrap_en (wrap_en), .use_imm (use_imm), .shf_type (shf_type),
    .lo_word (lo_word), .hi_word (hi_word), .amt_reg (amt_reg), .amt_imm (amt_imm),
    .out_valid (out_valid), .out_word (out_word)
  );

  function automatic longint eff_amt(input logic [1:0] t, input logic wr, input logic ui,
                                     input logic [AW-1:0] ar, input logic [IW-1:0] ai);
    longint a;
    longint sz;
    a  = ui ? longint'(ai) : longint'($signed(ar));
    sz = (t == 2'b00) ? 32 : 64;
    if (wr) return a & (sz - 1);
    if (a < 0) return 0;
    if (a > sz) return sz;
    return a;
  endfunction

  function automatic logic [W-1:0] model(input logic [1:0] t, input logic dl, input longint s,
                                         input logic [W-1:0] lo, input logic [W-1:0] hi);
    logic [63:0] cat;
    logic [63:0] r;
    cat = {hi, lo};
    if (t != 2'b00 && s == 0) return hi;
    if (dl) begin
      r = cat << s;
      return r[63:32];
    end
    if (t == 2'b10) begin
      if (s == 64) return '0;
      r = $signed(cat) >>> s;
      return r[31:0];
    end
    r = cat >> s;
    return r[31:0];
  endfunction

  task automatic shift_check(input logic [1:0] t, input logic dl, input logic wr, input logic ui,
                             input logic [W-1:0] lo, input logic [W-1:0] hi,
                             input logic [AW-1:0] ar, input logic [IW-1:0] ai, input string grp);
    longint s;
    logic [W-1:0] exp;
    string cat;
    @(negedge clk);
    in_valid = 1'b1; shf_type = t; dir_left = dl; wrap_en = wr; use_imm = ui;
    lo_word = lo; hi_word = hi; amt_reg = ar; amt_imm = ai;
    s   = eff_amt(t, wr, ui, ar, ai);
    exp = model(t, dl, s, lo, hi);
    if (t != 2'b00 && s == 0) cat = "R10";
    else if (t == 2'b00 && s == 0) cat = "R5";
    else if (t == 2'b00 && s == 32) cat = "R8";
    else if (s >= 32) cat = "R9";
    else cat = dl ? "R7" : "R6";
    @(posedge clk);
    #5;
    checks++;
    if (out_valid !== 1'b1 || out_word !== exp) begin
      errors++;
      $display("FAIL %s/%s/R11 type=%0d left=%0d wrap=%0d imm=%0d amt=%0d: actual valid=%0b word=%h expected valid=1 word=%h",
               grp, cat, t, dl, wr, ui, s, out_valid, out_word, exp);
    end
  endtask

  task automatic plain_check(input bit ok, input string req, input logic [W-1:0] act,
                             input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] los [3];
    logic [W-1:0] his [3];
    logic [W-1:0] held;
    los[0] = 32'h89AB_CDEF; his[0] = 32'h8123_4567;
    los[1] = 32'h0F0F_1234; his[1] = 32'h7654_3210;
    los[2] = 32'hFFFF_FFFF; his[2] = 32'h0000_0001;

    rst_n = 1'b1; in_valid = 1'b0; dir_left = 1'b0; wrap_en = 1'b0; use_imm = 1'b0;
    shf_type = 2'b00; lo_word = '0; hi_word = '0; amt_reg = '0; amt_imm = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    // R12: reset state while reset is held
    plain_check(out_valid === 1'b0, "R12 valid in reset", {31'b0, out_valid}, '0);
    plain_check(out_word === '0, "R12 word in reset", out_word, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #5;
    plain_check(out_valid === 1'b0, "R12 valid after release", {31'b0, out_valid}, '0);
    plain_check(out_word === '0, "R12 word after release", out_word, '0);

    // Register amount sweep: R3 (wrap), R4 (clamp), R1 for code 11
    for (int t = 0; t < 4; t++)
      for (int dl = 0; dl < 2; dl++)
        for (int wr = 0; wr < 2; wr++)
          for (int p = 0; p < 3; p++)
            for (int a = -70; a <= 140; a++)
              shift_check(2'(t), 1'(dl), 1'(wr), 1'b0, los[p], his[p], AW'(a), 6'd17,
                          (t == 3) ? "R1" : (wr != 0 ? "R3" : "R4"));

    // Extreme register amounts, clamp and wrap (R4, R3)
    for (int t = 0; t < 4; t++)
      for (int dl = 0; dl < 2; dl++)
        for (int wr = 0; wr < 2; wr++) begin
          shift_check(2'(t), 1'(dl), 1'(wr), 1'b0, los[0], his[0], 32'h8000_0000, '0, "R4");
          shift_check(2'(t), 1'(dl), 1'(wr), 1'b0, los[0], his[0], 32'h7FFF_FFFF, '0, "R4");
          shift_check(2'(t), 1'(dl), 1'(wr), 1'b0, los[1], his[1], 32'h0000_0100, '0, "R3");
          shift_check(2'(t), 1'(dl), 1'(wr), 1'b0, los[1], his[1], 32'hFFFF_FFC1, '0, "R3");
        end

    // Immediate sweep with a decoy register amount (R2)
    for (int t = 0; t < 4; t++)
      for (int dl = 0; dl < 2; dl++)
        for (int wr = 0; wr < 2; wr++)
          for (int p = 0; p < 3; p++)
            for (int ai = 0; ai < 64; ai++)
              shift_check(2'(t), 1'(dl), 1'(wr), 1'b1, los[p], his[p], 32'h5A5A_0003, 6'(ai), "R2");

    // R11: idle cycles hold the result and drop valid
    held = out_word;
    @(negedge clk);
    in_valid = 1'b0; lo_word = 32'hDEAD_BEEF; hi_word = 32'h1357_9BDF; amt_reg = 32'd5;
    @(posedge clk);
    #5;
    plain_check(out_valid === 1'b0, "R11 valid drops", {31'b0, out_valid}, '0);
    plain_check(out_word === held, "R11 word holds", out_word, held);
    @(posedge clk);
    #5;
    plain_check(out_word === held, "R11 word still holds", out_word, held);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule